// File: doc/BRIEF.md
# SAR ADC controller

This block is the digital side of a 10-bit successive-approximation converter. A host programs a control register over a simple byte-wide write port. The register holds the module enable, the input channel code, the choice of reference for each end of the range, and a combined start/busy bit. The block sends the channel code and the reference choice to the analog front end. It then runs the binary search for the result. It drives a trial code to the DAC each cycle and reads back a single comparator bit. When the search finishes, the block writes the result into a high/low register pair and sets a sticky interrupt flag.

The conversion engine is a three-state machine with the states IDLE, CONV and LOAD. It moves from IDLE to CONV on an accepted start and stays in CONV for one cycle per result bit. It goes from CONV to LOAD after the least significant trial, and from LOAD back to IDLE, always. Reset puts the engine in IDLE from any state and clears the control and flag registers. It does not touch the result pair.

The register map is:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bit 0 enable, bit 1 start/busy, bits 5:2 channel code, bit 6 positive reference external, bit 7 negative reference external |
| 1 | flag | bit 0 interrupt flag |
| 2 | result high | result bits 9:8 in bits 1:0, upper bits read 0 |
| 3 | result low | result bits 7:0 |

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, control (address 0) and flag (address 1) read 0x00, `irq` is 0 and `dac_code` is 0.
- R2: A write to address 0 with bits 0 and 1 both set starts a conversion when the stored enable is 1 and no conversion is running. Bit 1 of the control register reads 1 from the next cycle on.
- R3: If the stored enable is 0, a write with bit 1 set starts nothing. Bit 1 reads 0 and `irq` stays 0. The other fields of the write are still stored.
- R4: While a conversion runs, every write to address 0 is ignored. The channel and reference outputs keep their values, and the running conversion keeps its length.
- R5: The search is MSB first. In the first conversion cycle `dac_code` is 0x200. Each trial bit is kept when `cmp_hi` is 1 and cleared when it is 0. For a comparator that reports input >= `dac_code`, the result equals the input code.
- R6: A conversion lasts 11 cycles, 10 trials plus one load. `irq` is visible 11 clock edges after the edge that accepted the start.
- R7: On the edge that ends a conversion, the result pair is loaded, bit 1 of control clears and `irq` sets, all on that one edge.
- R8: The result is right-justified. Address 2 holds result bits 9:8 in bits 1:0 with zeros above, and address 3 holds bits 7:0.
- R9: `irq` stays set until the host writes 0 to bit 0 of address 1. Writing 1 there has no effect.
- R10: A reset during a conversion aborts it (`dac_code` returns to 0 and no `irq` follows), and the result pair keeps the value it held before the reset.
- R11: `ch_sel` follows the stored channel code. `ch_valid` is 0 only for code 0101, which has no input behind it.
- R12: `ref_pos_ext` follows control bit 6 and `ref_neg_ext` follows control bit 7. A 1 selects the external reference pin and a 0 selects the supply rail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register address for the read |
| rd_data | output | 8 | Combinational read data |
| cmp_hi | input | 1 | Comparator: 1 when the sampled input is at or above the DAC level |
| ch_sel | output | 4 | Channel code to the analog multiplexer |
| ch_valid | output | 1 | Low when the channel code has no input connected |
| ref_pos_ext | output | 1 | Positive reference: 1 external pin, 0 supply |
| ref_neg_ext | output | 1 | Negative reference: 1 external pin, 0 ground |
| dac_code | output | 10 | Trial code to the DAC during a conversion, 0 otherwise |
| irq | output | 1 | Sticky conversion-complete flag |

## Verification
The assertions assume three things about the inputs. `cmp_hi` is a settled function of the current `dac_code` within each CONV cycle. Writes are single-cycle strobes. The flag-clear write is the only way the host may lower `irq`. The stimulus keeps within these by deriving the comparator from a held input code compared against `dac_code`. It forces that input to zero for the unconnected channel code, and it issues every write as a one-cycle pulse driven on the falling edge.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_LOAD
    } conv_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_FLAG  = 2'd1;
    localparam logic [1:0] ADDR_RES_H = 2'd2;
    localparam logic [1:0] ADDR_RES_L = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_GO_BIT   = 1;
    localparam int CTRL_CH_LSB   = 2;
    localparam int CTRL_REFP_BIT = 6;
    localparam int CTRL_REFN_BIT = 7;

endpackage

// File: rtl/sar_engine.sv
module sar_engine
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    localparam int IDX_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cmp_hi,
    output logic                busy,
    output logic                load,
    output logic [RES_BITS-1:0] result,
    output logic [RES_BITS-1:0] dac_code
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);

    conv_state_t         state_q;
    conv_state_t         state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [RES_BITS-1:0] acc_q;
    logic [RES_BITS-1:0] trial;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CONV;
            ST_CONV: if (idx_q == '0) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // approximation register and bit pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            acc_q <= '0;
            idx_q <= TOP_IDX;
        end else if (state_q == ST_CONV) begin
            acc_q[idx_q] <= cmp_hi;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        trial        = '0;
        trial[idx_q] = 1'b1;
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        load     = 1'b0;
        dac_code = '0;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_CONV: dac_code = acc_q | trial;
            ST_LOAD: load = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign result = acc_q;

endmodule

// File: rtl/sar_regfile.sv
module sar_regfile
    import sar_adc_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int DATA_W   = 8,
    parameter int CH_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [1:0]          rd_addr,
    input  logic                busy,
    input  logic                load,
    input  logic [RES_BITS-1:0] result,
    output logic [DATA_W-1:0]   rd_data,
    output logic                start,
    output logic [CH_W-1:0]     chan,
    output logic [1:0]          refcfg,
    output logic                irq
);

    logic                en_q;
    logic [CH_W-1:0]     chan_q;
    logic [1:0]          ref_q;
    logic                flag_q;
    logic [RES_BITS-1:0] res_q;
    logic                ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL) && !busy;
    assign start   = ctrl_wr && en_q && wr_data[CTRL_EN_BIT] && wr_data[CTRL_GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            chan_q <= '0;
            ref_q  <= '0;
        end else if (ctrl_wr) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            chan_q <= wr_data[CTRL_CH_LSB +: CH_W];
            ref_q  <= {wr_data[CTRL_REFN_BIT], wr_data[CTRL_REFP_BIT]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (load) begin
            flag_q <= 1'b1;
        end else if (wr_en && wr_addr == ADDR_FLAG && !wr_data[0]) begin
            flag_q <= 1'b0;
        end
    end

    // result pair has no reset value
    always_ff @(posedge clk) begin
        if (load) begin
            res_q <= result;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]           = en_q;
                rd_data[CTRL_GO_BIT]           = busy;
                rd_data[CTRL_CH_LSB +: CH_W]   = chan_q;
                rd_data[CTRL_REFP_BIT]         = ref_q[0];
                rd_data[CTRL_REFN_BIT]         = ref_q[1];
            end
            ADDR_FLAG:  rd_data[0] = flag_q;
            ADDR_RES_H: rd_data = DATA_W'(res_q[RES_BITS-1:DATA_W]);
            ADDR_RES_L: rd_data = res_q[DATA_W-1:0];
            default:    rd_data = '0;
        endcase
    end

    assign chan   = chan_q;
    assign refcfg = ref_q;
    assign irq    = flag_q;

endmodule

// File: rtl/sar_front_if.sv
module sar_front_if #(
    parameter int          CH_W       = 4,
    parameter logic [3:0]  NO_CH_CODE = 4'b0101
) (
    input  logic [CH_W-1:0] chan,
    input  logic [1:0]      refcfg,
    output logic [CH_W-1:0] ch_sel,
    output logic            ch_valid,
    output logic            ref_pos_ext,
    output logic            ref_neg_ext
);

    assign ch_sel      = chan;
    assign ch_valid    = (chan != CH_W'(NO_CH_CODE));
    assign ref_pos_ext = refcfg[0];
    assign ref_neg_ext = refcfg[1];

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int RES_BITS = 10,
    parameter int DATA_W   = 8,
    parameter int CH_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [1:0]          rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                cmp_hi,
    output logic [CH_W-1:0]     ch_sel,
    output logic                ch_valid,
    output logic                ref_pos_ext,
    output logic                ref_neg_ext,
    output logic [RES_BITS-1:0] dac_code,
    output logic                irq
);

    logic                conv_busy;
    logic                conv_load;
    logic                conv_start;
    logic [RES_BITS-1:0] conv_result;
    logic [CH_W-1:0]     chan;
    logic [1:0]          refcfg;

    sar_regfile #(
        .RES_BITS (RES_BITS),
        .DATA_W   (DATA_W),
        .CH_W     (CH_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .busy    (conv_busy),
        .load    (conv_load),
        .result  (conv_result),
        .rd_data (rd_data),
        .start   (conv_start),
        .chan    (chan),
        .refcfg  (refcfg),
        .irq     (irq)
    );

    sar_engine #(
        .RES_BITS (RES_BITS)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .cmp_hi   (cmp_hi),
        .busy     (conv_busy),
        .load     (conv_load),
        .result   (conv_result),
        .dac_code (dac_code)
    );

    sar_front_if #(
        .CH_W (CH_W)
    ) u_front (
        .chan        (chan),
        .refcfg      (refcfg),
        .ch_sel      (ch_sel),
        .ch_valid    (ch_valid),
        .ref_pos_ext (ref_pos_ext),
        .ref_neg_ext (ref_neg_ext)
    );

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                irq,
    input logic                wr_clr,
    input logic [RES_BITS-1:0] dac_code
);

    localparam int CONV_CYC = RES_BITS + 1;
    localparam int CNT_W    = $clog2(CONV_CYC + 1) + 1;
    localparam logic [RES_BITS-1:0] MSB_TRIAL = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R5
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == MSB_TRIAL);

    // R6
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == CNT_W'(CONV_CYC));

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < CNT_W'(CONV_CYC));

    // R7
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !wr_clr |=> irq);

    // R10
    idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dac_code == '0);

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (conv_busy),
    .irq      (irq),
    .wr_clr   (wr_en && (wr_addr == 2'd1) && !wr_data[0]),
    .dac_code (dac_code)
);

// File: tb/sim_sar_adc_ctrl.sv
`timescale 1ns/100ps
module sim_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cmp_hi;
    logic [3:0] ch_sel;
    logic       ch_valid;
    logic       ref_pos_ext;
    logic       ref_neg_ext;
    logic [9:0] dac_code;
    logic       irq;

    logic [9:0] vin = '0;
    logic [9:0] exp_q[$];
    int         n_chk = 0;
    int         n_err = 0;
    int         mon_cnt = 0;
    logic [7:0] rd_val;

    always #2 clk = ~clk;

    // analog model: code 0101 has no input, reads as zero
    assign cmp_hi = ((ch_sel == 4'd5) ? 10'd0 : vin) >= dac_code;

    sar_adc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmp_hi(cmp_hi), .ch_sel(ch_sel), .ch_valid(ch_valid),
        .ref_pos_ext(ref_pos_ext), .ref_neg_ext(ref_neg_ext),
        .dac_code(dac_code), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.2;
        d = rd_data;
    endtask

    // monitor: pops the scoreboard when a conversion completes
    initial begin
        logic [7:0] hi, lo, ct;
        logic [9:0] e;
        forever begin
            @(posedge irq);
            @(negedge clk);
            rd_addr = 2'd2; #0.2; hi = rd_data;
            rd_addr = 2'd3; #0.2; lo = rd_data;
            rd_addr = 2'd0; #0.2; ct = rd_data;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected completion", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(hi == {6'b0, e[9:8]}, "R8 R5 result high", hi, {6'b0, e[9:8]});
                chk(lo == e[7:0], "R8 R5 result low", lo, e[7:0]);
            end
            chk(ct[1] == 1'b0, "R7 busy clear with irq", ct[1], 0);
            mon_cnt++;
        end
    end

    task automatic run_conv(input logic [3:0] ch, input logic [9:0] v);
        int k;
        int m0;
        vin = v;
        exp_q.push_back((ch == 4'd5) ? 10'd0 : v);
        m0 = mon_cnt;
        wr(2'd0, {2'b00, ch, 2'b11});
        rd(2'd0, rd_val);
        chk(rd_val[1] == 1'b1, "R2 busy after start", rd_val[1], 1);
        chk(ch_sel == ch, "R11 ch_sel", ch_sel, ch);
        chk(ch_valid == (ch != 4'd5), "R11 ch_valid", ch_valid, ch != 4'd5);
        k = 0;
        while (!irq && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk(k == 11, "R6 conversion length", k, 11);
        wait (mon_cnt != m0);
        wr(2'd1, 8'h01);
        chk(irq == 1'b1, "R9 write one keeps irq", irq, 1);
        wr(2'd1, 8'h00);
        chk(irq == 1'b0, "R9 write zero clears irq", irq, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(2'd0, rd_val); chk(rd_val == 8'h00, "R1 control reset", rd_val, 0);
        rd(2'd1, rd_val); chk(rd_val == 8'h00, "R1 flag reset", rd_val, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);
        chk(dac_code == 10'd0, "R1 dac_code reset", dac_code, 0);

        // R3: start while disabled
        wr(2'd0, 8'b00_0011_10);
        rd(2'd0, rd_val);
        chk(rd_val[1] == 1'b0, "R3 start ignored when disabled", rd_val[1], 0);
        chk(ch_sel == 4'd3, "R3 R11 fields stored", ch_sel, 3);
        repeat (15) @(negedge clk);
        chk(irq == 1'b0, "R3 no irq", irq, 0);

        // R12
        wr(2'd0, 8'b01_0011_01);
        chk(ref_pos_ext == 1'b1 && ref_neg_ext == 1'b0, "R12 refs 01", {ref_neg_ext, ref_pos_ext}, 1);
        wr(2'd0, 8'b10_0011_01);
        chk(ref_pos_ext == 1'b0 && ref_neg_ext == 1'b1, "R12 refs 10", {ref_neg_ext, ref_pos_ext}, 2);

        // conversions
        run_conv(4'd0, 10'd0);
        run_conv(4'd1, 10'd1023);
        run_conv(4'd2, 10'd512);
        run_conv(4'd3, 10'd511);
        run_conv(4'd15, 10'h2AA);
        run_conv(4'd12, 10'h155);
        run_conv(4'd5, 10'd700);
        run_conv(4'd9, 10'd1);

        // R4: writes while busy are ignored
        vin = 10'd300;
        exp_q.push_back(10'd300);
        wr(2'd0, {2'b00, 4'd2, 2'b11});
        chk(dac_code == 10'h200, "R5 first trial", dac_code, 10'h200);
        repeat (2) @(negedge clk);
        wr(2'd0, {2'b11, 4'd7, 2'b11});
        chk(ch_sel == 4'd2, "R4 channel held", ch_sel, 2);
        chk(ref_pos_ext == 1'b0 && ref_neg_ext == 1'b0, "R4 refs held", {ref_neg_ext, ref_pos_ext}, 0);
        k = 4;
        while (!irq && k < 50) begin
            @(negedge clk);
            k++;
        end
        chk(k == 11, "R4 length unchanged", k, 11);
        wait (mon_cnt == 9);
        wr(2'd1, 8'h00);

        // R10: reset aborts, result kept (last result 300)
        vin = 10'd77;
        wr(2'd0, {2'b00, 4'd4, 2'b11});
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(dac_code == 10'd0, "R10 dac idle after abort", dac_code, 0);
        rd(2'd0, rd_val); chk(rd_val == 8'h00, "R10 control cleared", rd_val, 0);
        rd(2'd2, rd_val); chk(rd_val == 8'h01, "R10 result high kept", rd_val, 8'h01);
        rd(2'd3, rd_val); chk(rd_val == 8'h2C, "R10 result low kept", rd_val, 8'h2C);
        repeat (15) @(negedge clk);
        chk(irq == 1'b0, "R10 no irq after abort", irq, 0);

        // recovery after abort
        wr(2'd0, 8'h01);
        run_conv(4'd6, 10'd640);

        summary();
        $finish;
    end

endmodule